// File: doc/BRIEF.md
# Multi-Dimensional Affine Address Generator

This block walks a nest of up to four counting loops and turns the loop indices into memory addresses. The address is a base value plus, for each active loop level, that level's index times its stride, wrapped to the address width. Level 0 is the innermost loop. It advances on every accepted step. When it finishes its count it returns to zero and carries one into the next level, and so on up the nest.

The number of active levels, one count and one stride per level, and the base address all come from configuration inputs. These must be held steady while the walk runs; a reset restarts the walk from the base. On each accepted step (step high, stall low) the address for the current indices is registered onto the output, the active flag is raised for that cycle, and the indices move to the next point. A common setup is two levels with strides 1 and 512, which gives a linear raster over a two-dimensional array.

Top module: `affine_addr_gen`

## Requirements
- R1: After reset, active_o is 0 and addr_o is 0, and the first accepted step outputs cfg_start.
- R2: Each accepted step outputs cfg_start plus the sum, over active levels, of index times stride, taken modulo 2^AW.
- R3: Level 0 is innermost and advances on every accepted step. A level whose index equals its count minus 1 returns to 0 and carries one step into the next level.
- R4: Levels numbered at or above the active level count hold index 0, and their count and stride have no effect on the addresses.
- R5: When every active level is at its last index on an accepted step, the next accepted step outputs cfg_start again.
- R6: With step low or stall high, no indices change, addr_o keeps its value and active_o is 0. The walk then resumes at the point where it stopped.
- R7: active_o is 1 exactly in the cycle after an accepted step (registered, one cycle of latency).
- R8: A level count of 0 behaves like a count of 1: that level stays at index 0 and carries on every step it receives.
- R9: A level count value in cfg_dims above NDIM is treated as NDIM.
- R10: With two levels, strides 1 and 512 and a level 0 count of 512, consecutive accepted steps give consecutive addresses, including across the 512 boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dims | input | $clog2(NDIM+1) | Number of active loop levels |
| cfg_start | input | AW | Base address used when all indices are zero |
| cfg_range | input | NDIM*CW | Per-level counts, level i in bits [i*CW +: CW] |
| cfg_stride | input | NDIM*AW | Per-level strides, level i in bits [i*AW +: AW] |
| step | input | 1 | Request to emit one address and advance |
| stall | input | 1 | Blocks the step when high |
| addr_o | output | AW | Registered address of the last accepted step |
| active_o | output | 1 | High for the cycle after an accepted step |

## Verification
The assertions assume that cfg_dims, cfg_range and cfg_stride stay constant between resets. The index-range and hold properties rely on this, because a count lowered in the middle of a walk would leave an index above its new limit. The stimulus respects this assumption. Every new configuration, directed or random, is applied while rst_n is low, and only step and stall change during a walk. Random phases use counts from 1 to 6 and full-width strides and bases, so address wrap-around is exercised.

// File: rtl/affine_ag_pkg.sv
package affine_ag_pkg;

    // limit a requested level count to the number of built levels
    function automatic int unsigned ag_clamp(input int unsigned raw, input int unsigned lim);
        return (raw > lim) ? lim : raw;
    endfunction

endpackage

// File: rtl/affine_dim_counter.sv
module affine_dim_counter #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic          adv,
    input  logic [CW-1:0] rng,
    output logic [CW-1:0] idx,
    output logic          last
);
    typedef struct packed {
        logic [CW-1:0] idx;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic at_end;

    // count 0 or 1 both end after index 0
    assign at_end = ({1'b0, cnt_q.idx} + (CW+1)'(1)) >= {1'b0, rng};
    assign last   = !act || at_end;
    assign idx    = cnt_q.idx;

    always_comb begin
        cnt_d = cnt_q;
        if (!act) begin
            cnt_d.idx = '0;
        end else if (adv) begin
            cnt_d.idx = at_end ? '0 : cnt_q.idx + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && rng != '0) |-> (cnt_q.idx < rng));

    // R6
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !adv) |=> $stable(cnt_q.idx));

endmodule

// File: rtl/affine_addr_sum.sv
module affine_addr_sum #(
    parameter int unsigned NDIM = 4,
    parameter int unsigned AW   = 16,
    parameter int unsigned CW   = 16
) (
    input  logic [AW-1:0]      base,
    input  logic [NDIM*CW-1:0] idx_flat,
    input  logic [NDIM*AW-1:0] stride_flat,
    input  logic [NDIM-1:0]    act,
    output logic [AW-1:0]      addr
);
    logic [NDIM-1:0][AW-1:0] term;

    for (genvar g = 0; g < NDIM; g++) begin : g_term
        logic [AW-1:0] idx_w;
        assign idx_w   = AW'(idx_flat[g*CW +: CW]);
        assign term[g] = act[g] ? (idx_w * stride_flat[g*AW +: AW]) : '0;
    end

    always_comb begin
        addr = base;
        for (int i = 0; i < int'(NDIM); i++) begin
            addr = addr + term[i];
        end
    end

endmodule

// File: rtl/affine_addr_gen.sv
module affine_addr_gen #(
    parameter int unsigned NDIM = 4,
    parameter int unsigned AW   = 16,
    parameter int unsigned CW   = 16,
    localparam int unsigned DW  = $clog2(NDIM + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DW-1:0]      cfg_dims,
    input  logic [AW-1:0]      cfg_start,
    input  logic [NDIM*CW-1:0] cfg_range,
    input  logic [NDIM*AW-1:0] cfg_stride,
    input  logic               step,
    input  logic               stall,
    output logic [AW-1:0]      addr_o,
    output logic               active_o
);
    import affine_ag_pkg::*;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          active;
    } out_t;

    out_t              out_d, out_q;
    int unsigned       eff_dims;
    logic              fire;
    logic              wrap_all;
    logic [NDIM-1:0]   dim_act;
    logic [NDIM-1:0]   dim_adv;
    logic [NDIM-1:0]   dim_last;
    logic [NDIM*CW-1:0] idx_flat;
    logic [AW-1:0]     cur_addr;

    assign eff_dims = ag_clamp(int'(cfg_dims), NDIM);
    assign fire     = step && !stall;
    assign wrap_all = &dim_last;

    for (genvar g = 0; g < NDIM; g++) begin : g_dim
        assign dim_act[g] = (32'(g) < eff_dims);
        if (g == 0) begin : g_first
            assign dim_adv[g] = fire;
        end else begin : g_rest
            assign dim_adv[g] = dim_adv[g-1] && dim_last[g-1];
        end

        affine_dim_counter #(.CW(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .act   (dim_act[g]),
            .adv   (dim_adv[g]),
            .rng   (cfg_range[g*CW +: CW]),
            .idx   (idx_flat[g*CW +: CW]),
            .last  (dim_last[g])
        );
    end

    affine_addr_sum #(.NDIM(NDIM), .AW(AW), .CW(CW)) u_sum (
        .base        (cfg_start),
        .idx_flat    (idx_flat),
        .stride_flat (cfg_stride),
        .act         (dim_act),
        .addr        (cur_addr)
    );

    always_comb begin
        out_d        = out_q;
        out_d.active = fire;
        if (fire) begin
            out_d.addr = cur_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign addr_o   = out_q.addr;
    assign active_o = out_q.active;

    // R2
    addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (addr_o == $past(cur_addr)));

    // R7
    active_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> $past(step && !stall));

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && wrap_all) |=> (idx_flat == '0));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(addr_o) && !active_o));

endmodule

// File: tb/affine_addr_gen_test.sv
`timescale 1ns/1ps
module affine_addr_gen_test;
    localparam int unsigned NDIM = 4;
    localparam int unsigned AW   = 16;
    localparam int unsigned CW   = 16;
    localparam int unsigned DW   = $clog2(NDIM + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [DW-1:0]      cfg_dims = '0;
    logic [AW-1:0]      cfg_start = '0;
    logic [NDIM*CW-1:0] cfg_range = '0;
    logic [NDIM*AW-1:0] cfg_stride = '0;
    logic               step = 1'b0;
    logic               stall = 1'b0;
    logic [AW-1:0]      addr_o;
    logic               active_o;

    always #2 clk = ~clk;

    affine_addr_gen #(.NDIM(NDIM), .AW(AW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_dims(cfg_dims), .cfg_start(cfg_start),
        .cfg_range(cfg_range), .cfg_stride(cfg_stride), .step(step),
        .stall(stall), .addr_o(addr_o), .active_o(active_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int unsigned m_idx [NDIM];
    int unsigned c_rng [NDIM];
    int unsigned c_str [NDIM];
    int unsigned c_start;
    int unsigned c_dims;
    logic          exp_act;
    logic [AW-1:0] exp_addr;

    function automatic int unsigned eff_lv();
        return (c_dims > NDIM) ? NDIM : c_dims;
    endfunction

    function automatic logic [AW-1:0] model_addr();
        logic [31:0] s;
        s = c_start;
        for (int i = 0; i < int'(eff_lv()); i++) s = s + m_idx[i] * c_str[i];
        return s[AW-1:0];
    endfunction

    function automatic void model_adv();
        for (int i = 0; i < int'(eff_lv()); i++) begin
            if (m_idx[i] + 1 >= c_rng[i]) begin
                m_idx[i] = 0;
            end else begin
                m_idx[i] = m_idx[i] + 1;
                return;
            end
        end
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic load_and_reset();
        rst_n = 1'b0;
        step  = 1'b0;
        stall = 1'b0;
        cfg_dims  = DW'(c_dims);
        cfg_start = AW'(c_start);
        for (int i = 0; i < int'(NDIM); i++) begin
            cfg_range[i*CW +: CW]  = CW'(c_rng[i]);
            cfg_stride[i*AW +: AW] = AW'(c_str[i]);
            m_idx[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n    = 1'b1;
        exp_act  = 1'b0;
        exp_addr = '0;
        check("R1", 32'(active_o), 32'(0));
        check("R1", 32'(addr_o), 32'(0));
    endtask

    task automatic cycle(input string tag, input bit s, input bit st);
        step  = s;
        stall = st;
        if (s && !st) begin
            exp_addr = model_addr();
            model_adv();
        end
        exp_act = s && !st;
        @(negedge clk);
        check("R7", 32'(active_o), 32'(exp_act));
        check(tag, 32'(addr_o), 32'(exp_addr));
    endtask

    task automatic set_cfg(input int unsigned d, input int unsigned st,
                           input int unsigned r0, input int unsigned r1,
                           input int unsigned r2, input int unsigned r3,
                           input int unsigned s0, input int unsigned s1,
                           input int unsigned s2, input int unsigned s3);
        c_dims = d; c_start = st;
        c_rng[0] = r0; c_rng[1] = r1; c_rng[2] = r2; c_rng[3] = r3;
        c_str[0] = s0; c_str[1] = s1; c_str[2] = s2; c_str[3] = s3;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));

        // R1, R3, R5: two levels, counts 4 and 3
        set_cfg(2, 32'h100, 4, 3, 9, 9, 1, 16, 7, 7);
        load_and_reset();
        cycle("R1", 1, 0);
        check("R1", 32'(addr_o), 32'h100);
        for (int k = 1; k < 12; k++) cycle("R3", 1, 0);
        check("R3", 32'(addr_o), 32'h100 + 3 + 2*16);
        cycle("R5", 1, 0);
        check("R5", 32'(addr_o), 32'h100);

        // R6: stall and idle keep state
        for (int k = 0; k < 4; k++) cycle("R6", 1, 1);
        check("R6", 32'(active_o), 32'(0));
        for (int k = 0; k < 3; k++) cycle("R6", 0, 0);
        cycle("R6", 1, 0);
        check("R6", 32'(addr_o), 32'h101);

        // R4: upper levels carry junk config
        set_cfg(2, 32'h40, 3, 2, 5, 2, 2, 32, 32'h777, 32'h55);
        load_and_reset();
        for (int k = 0; k < 30; k++) cycle("R4", 1, 0);

        // R8: count 0 on level 0
        set_cfg(2, 0, 0, 5, 1, 1, 3, 100, 0, 0);
        load_and_reset();
        for (int k = 0; k < 12; k++) cycle("R8", 1, 0);
        check("R8", 32'(addr_o), 32'(100 * 1));

        // R9: level count above NDIM
        set_cfg(7, 32'h10, 2, 2, 2, 2, 1, 2, 4, 8);
        load_and_reset();
        for (int k = 0; k < 20; k++) cycle("R9", 1, 0);

        // R10: raster over 512-wide rows
        set_cfg(2, 0, 512, 3, 1, 1, 1, 512, 0, 0);
        load_and_reset();
        for (int k = 0; k < 1536; k++) begin
            cycle("R10", 1, 0);
            if (k == 511 || k == 512 || k == 1535) check("R10", 32'(addr_o), 32'(k));
        end
        cycle("R10", 1, 0);
        check("R10", 32'(addr_o), 32'(0));

        // R2: random configurations and step/stall patterns
        for (int c = 0; c < 6; c++) begin
            set_cfg(1 + ($urandom % 4), $urandom % 65536,
                    1 + ($urandom % 6), 1 + ($urandom % 6),
                    1 + ($urandom % 6), 1 + ($urandom % 6),
                    $urandom % 65536, $urandom % 65536,
                    $urandom % 65536, $urandom % 65536);
            load_and_reset();
            for (int k = 0; k < 300; k++) cycle("R2", ($urandom % 4) != 0, ($urandom % 5) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule